// File: doc/BRIEF.md
# Double-Buffered Byte-Loaded Converter Code Register

This block is the digital front end of a 14-bit digital-to-analog converter that sits on an 8-bit processor bus. Software builds a 14-bit code in a staging register one byte at a time: one location takes the six upper bits, another takes the eight lower bits. A third location copies the staged value into the live register. The live register drives the converter code output. While software writes the staging register, the output keeps the previous code.

Several instances can share one active-low load line. Software fills each instance's staging register in turn through its own chip select. A single falling edge on the shared line then moves every staged value into its live register in the same clock cycle, so all converter outputs step together. The load line may be asynchronous to the clock. It passes through a two-flop synchronizer, and a transfer fires once per falling edge.

Top module: `dac_dbuf_front`

## Requirements
- R1: Reset clears the staging register and the live register to zero. After reset, `code` reads 0, and a transfer issued before any byte write still gives 0.
- R2: A write to address 1 (both `cs_n` and `wr_n` low at a rising clock edge) stores `data[5:0]` into staging bits [13:8]. `data[7:6]` has no effect.
- R3: A write to address 2 stores `data[7:0]` into staging bits [7:0].
- R4: Writes to address 1 or address 2 leave `code` unchanged.
- R5: A write to address 3 copies the staging register into the live register. `code` shows the new value after that same clock edge.
- R6: A write to address 0 changes neither the staging register nor `code`.
- R7: No write takes place unless `cs_n` and `wr_n` are both low in the same cycle.
- R8: The two bytes may be written in either order, and the transfer gives the same code.
- R9: A falling edge on `ld_n` causes exactly one transfer, at the third rising clock edge after `ld_n` goes low. Holding `ld_n` low, or raising it, causes no further transfer.
- R10: When an address-3 write and a load-edge transfer fall in the same cycle, one transfer happens. A byte write in a transfer cycle reaches the staging register, but the transfer copies the value held before that edge.
- R11: Instances that share `ld_n` update `code` in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register location select |
| data | input | 8 | Write data bus |
| ld_n | input | 1 | Shared active-low load line, may be asynchronous |
| code | output | 14 | Live converter code |

## Verification
On every cycle, the assertions check four things: each byte write lands in the correct half of the staging register, an address-0 write leaves the staging register alone, `code` moves only in the cycle after a transfer request, and a transfer copies exactly the staged value. They also check that a load edge produces a single request. The bench alone can show the following:
- the three-edge synchronizer latency;
- that two instances update in the same cycle;
- the byte-order independence;
- which staged value a transfer picks up when a byte write coincides with it.

The bench shows these with a sweep over all upper-byte values against spread lower-byte values, and with expected codes computed as upper*256+lower.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int CODE_W = 14;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 2;
    localparam int HI_W   = CODE_W - BUS_W;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] LOC_HI   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] LOC_LO   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] LOC_XFER = ADDR_W'(3);

    typedef struct packed {
        logic [CODE_W-1:0] staged;
        logic [CODE_W-1:0] live;
    } dacfe_state_t;
endpackage

// File: rtl/dacfe_decode.sv
module dacfe_decode
    import dacfe_pkg::*;
(
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              we_hi,
    output logic              we_lo,
    output logic              we_xfer
);
    logic strobe;

    assign strobe  = ~cs_n & ~wr_n;
    assign we_hi   = strobe && (addr == LOC_HI);
    assign we_lo   = strobe && (addr == LOC_LO);
    assign we_xfer = strobe && (addr == LOC_XFER);
endmodule

// File: rtl/dacfe_ld_sync.sv
module dacfe_ld_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_n_async,
    output logic ld_fall
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-1:0], ld_n_async};
    end

    assign ld_fall = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  data,
    input  logic              ld_n,
    output logic [CODE_W-1:0] code
);
    logic we_hi, we_lo, we_xfer, ld_fall, xfer_go;
    dacfe_state_t state_d, state_q;

    dacfe_decode u_decode (
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .addr   (addr),
        .we_hi  (we_hi),
        .we_lo  (we_lo),
        .we_xfer(we_xfer)
    );

    dacfe_ld_sync #(.STAGES(SYNC_STAGES)) u_ld_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_n_async(ld_n),
        .ld_fall   (ld_fall)
    );

    // a bus transfer and a load edge in one cycle merge into a single copy
    assign xfer_go = we_xfer | ld_fall;

    always_comb begin
        state_d = state_q;
        if (we_hi) state_d.staged[CODE_W-1 -: HI_W] = data[HI_W-1:0];
        if (we_lo) state_d.staged[BUS_W-1:0]        = data;
        if (xfer_go) state_d.live = state_q.staged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign code = state_q.live;
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker
    import dacfe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BUS_W-1:0]  data,
    input logic [CODE_W-1:0] code,
    input logic [CODE_W-1:0] staged,
    input logic              xfer_go,
    input logic              ld_fall
);
    // R2
    hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && addr == LOC_HI) |=> staged[CODE_W-1 -: HI_W] == $past(data[HI_W-1:0]));

    // R3
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && addr == LOC_LO) |=> staged[BUS_W-1:0] == $past(data));

    // R6
    loc0_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && addr == '0) |=> $stable(staged));

    // R4
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_go |=> $stable(code));

    // R5
    xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |=> code == $past(staged));

    // R9
    ld_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fall |=> !ld_fall);
endmodule

bind dac_dbuf_front dacfe_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .wr_n   (wr_n),
    .addr   (addr),
    .data   (data),
    .code   (code),
    .staged (state_q.staged),
    .xfer_go(xfer_go),
    .ld_fall(ld_fall)
);

// File: tb/dac_dbuf_front_bench.sv
module dac_dbuf_front_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cs_a_n = 1'b1, cs_b_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  data = '0;
    logic [13:0] code_a, code_b;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    dac_dbuf_front u_dac_dbuf_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_a_n), .wr_n(wr_n),
        .addr(addr), .data(data), .ld_n(ld_n), .code(code_a));

    dac_dbuf_front u_dac_dbuf_front_b (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_b_n), .wr_n(wr_n),
        .addr(addr), .data(data), .ld_n(ld_n), .code(code_b));

    task automatic chk(input string req, input logic [13:0] got, input logic [13:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drives one bus cycle; returns at the falling edge after the write edge
    task automatic bus_wr(input bit to_b, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        if (to_b) cs_b_n = 1'b0; else cs_a_n = 1'b0;
        wr_n = 1'b0; addr = a; data = d;
        @(negedge clk);
        cs_a_n = 1'b1; cs_b_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [13:0] prev_a;
        repeat (3) @(negedge clk);
        chk("R1 code_a in reset", code_a, 14'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 code_b after reset", code_b, 14'h0);
        bus_wr(0, 2'd3, 8'h00);
        chk("R1 staging cleared", code_a, 14'h0);
        prev_a = 14'h0;

        // sweep: every upper value against spread lower values
        for (int hi = 0; hi < 64; hi++) begin
            for (int lo = 0; lo < 256; lo += 17) begin
                bus_wr(0, 2'd1, {2'(hi ^ lo), 6'(hi)});
                chk("R4 after upper write", code_a, prev_a);
                bus_wr(0, 2'd2, 8'(lo));
                chk("R4 after lower write", code_a, prev_a);
                bus_wr(0, 2'd3, 8'h00);
                prev_a = 14'(hi * 256 + lo);
                chk("R5 R2 R3 transfer", code_a, prev_a);
            end
        end

        // R8 reverse order, upper bits of data set
        bus_wr(0, 2'd2, 8'h5A);
        bus_wr(0, 2'd1, 8'hEC);
        chk("R8 before transfer", code_a, prev_a);
        bus_wr(0, 2'd3, 8'h00);
        chk("R8 lower-first order", code_a, 14'h2C5A);

        // R6 address 0 ignored
        bus_wr(0, 2'd0, 8'hFF);
        chk("R6 code after addr0", code_a, 14'h2C5A);
        bus_wr(0, 2'd3, 8'h00);
        chk("R6 staging after addr0", code_a, 14'h2C5A);

        // R7 incomplete strobes
        @(negedge clk); cs_a_n = 1'b0; wr_n = 1'b1; addr = 2'd1; data = 8'h3F;
        @(negedge clk); cs_a_n = 1'b1; wr_n = 1'b0; addr = 2'd2; data = 8'h00;
        @(negedge clk); wr_n = 1'b1;
        bus_wr(0, 2'd3, 8'h00);
        chk("R7 no write without both strobes", code_a, 14'h2C5A);

        // R9 R11 shared load
        bus_wr(0, 2'd1, 8'h15); bus_wr(0, 2'd2, 8'hA3);
        bus_wr(1, 2'd1, 8'h3E); bus_wr(1, 2'd2, 8'h01);
        @(negedge clk); ld_n = 1'b0;
        @(negedge clk);
        chk("R9 edge1 code_a", code_a, 14'h2C5A);
        @(negedge clk);
        chk("R9 edge2 code_b", code_b, 14'h0);
        @(negedge clk);
        chk("R9 R11 edge3 code_a", code_a, 14'h15A3);
        chk("R11 edge3 code_b", code_b, 14'h3E01);
        bus_wr(0, 2'd1, 8'h01); bus_wr(0, 2'd2, 8'h02);
        repeat (4) @(negedge clk);
        chk("R9 held low no retransfer", code_a, 14'h15A3);
        ld_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 rising edge no transfer", code_a, 14'h15A3);

        // R10 bus transfer coinciding with load edge
        ld_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); cs_a_n = 1'b0; wr_n = 1'b0; addr = 2'd3;
        @(negedge clk); cs_a_n = 1'b1; wr_n = 1'b1;
        chk("R10 merged transfer", code_a, 14'h0102);
        repeat (3) @(negedge clk);
        chk("R10 single transfer", code_a, 14'h0102);
        ld_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10 byte write coinciding with load edge on instance b
        ld_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); cs_b_n = 1'b0; wr_n = 1'b0; addr = 2'd2; data = 8'h77;
        @(negedge clk); cs_b_n = 1'b1; wr_n = 1'b1;
        chk("R10 transfer uses pre-write value", code_b, 14'h3E01);
        chk("R11 code_a with shared edge", code_a, 14'h0102);
        ld_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_wr(1, 2'd3, 8'h00);
        chk("R10 byte write landed", code_b, 14'h3E77);

        finish_run();
    end
endmodule